// File: doc/BRIEF.md
# Two-Stage Multi-Bit Path Sorter

This block picks the surviving paths for a list decoder that decides several bits per step. Each of the `NUM_PATHS` current paths expands into `2^STEP_BITS` successor candidates, one for each bit pattern, and each candidate carries a metric. The sorter is approximate, so it does not run one exact selection over every candidate. Stage one reduces each path's successors to its `KEEP` best. Stage two then picks the `NUM_PATHS` best of the `NUM_PATHS*KEEP` survivors. The result can differ from a full global sort. In return the comparator logic is much smaller.

A frame is presented as one strobe together with every candidate metric. The winners appear two clock edges later as a sorted list. Each entry in the list holds the parent path, the bit pattern and the metric. A lower metric is better. A new frame may be accepted on every cycle.

Top module: `psort_two_stage`

## Requirements
- R1: While reset is asserted, and until the first frame emerges, `valid_o` is low and every data output is zero.
- R2: `valid_o` is high for exactly one cycle per frame. That cycle comes two rising edges after the cycle in which `valid_i` was high.
- R3: Output entry 0 is the best. Entries rise strictly by the key formed from metric, then parent, then pattern.
- R4: At most `KEEP` (2) entries share a parent. The entries of a parent are that parent's best patterns, so the list can leave out candidates that an exact global sort would keep.
- R5: Candidate `c = parent*4 + pattern` is unsigned `metric_i[c*8 +: 8]`. Entry k sits at `parent_o[k*2 +: 2]`, `pattern_o[k*2 +: 2]` and `metric_o[k*8 +: 8]`. Its metric equals the input metric at that index.
- R6: Equal metrics are ordered by the lower parent first, then by the lower pattern. This applies in both stages.
- R7: No two output entries have the same parent and pattern pair.
- R8: Frames presented on consecutive cycles each produce their own correct result on consecutive cycles.
- R9: `metric_i` is ignored when `valid_i` is low. While `valid_o` is low, the data outputs hold the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | A frame of candidate metrics is present |
| metric_i | input | NUM_PATHS*2^STEP_BITS*METRIC_W | Candidate metrics, indexed by parent*2^STEP_BITS + pattern |
| valid_o | output | 1 | The result list is valid |
| parent_o | output | NUM_PATHS*PAR_W | Parent path of each entry |
| pattern_o | output | NUM_PATHS*STEP_BITS | Bit pattern of each entry |
| metric_o | output | NUM_PATHS*METRIC_W | Metric of each entry |

## Verification
The bench targets the approximate case, in which one path owns all of the globally best candidates. An exact sorter, or one whose stage one is wrong, would let that path take more than two slots. The bench drives frames where every metric is equal, to check the tie order. A design that compares metrics alone would produce an unstable or duplicated order there. It also drives extremes of 0 and 255, and back-to-back frames. A pipeline-register slip would show up as results delayed or mixed between frames. Random frames with narrow metric ranges compare the output to a model built from the requirements. Garbage on `metric_i` while the strobe is low must leave the held result untouched.

// File: rtl/psort_pkg.sv
`timescale 1ns/1ps
package psort_pkg;
  localparam int unsigned DEF_PATHS     = 4;
  localparam int unsigned DEF_STEP_BITS = 2;
  localparam int unsigned DEF_KEEP      = 2;
  localparam int unsigned DEF_METRIC_W  = 8;

  // index width that never collapses to zero
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/psort_cx_sort.sv
`timescale 1ns/1ps
// Odd-even transposition network; keeps the KEEP smallest keys in order.
module psort_cx_sort #(
  parameter int unsigned N     = 4,
  parameter int unsigned KEY_W = 12,
  parameter int unsigned KEEP  = 2
) (
  input  logic [N*KEY_W-1:0]    key_i,
  output logic [KEEP*KEY_W-1:0] key_o
);
  logic [KEY_W-1:0] st [N+1][N];

  for (genvar i = 0; i < N; i++) begin : g_in
    assign st[0][i] = key_i[i*KEY_W +: KEY_W];
  end

  for (genvar s = 0; s < N; s++) begin : g_stage
    localparam int FIRST = s % 2;
    for (genvar i = 0; i < N; i++) begin : g_lane
      if (i >= FIRST && ((i - FIRST) % 2) == 0 && (i + 1) < N) begin : g_lo
        assign st[s+1][i] = (st[s][i+1] < st[s][i]) ? st[s][i+1] : st[s][i];
      end else if (i >= FIRST + 1 && ((i - 1 - FIRST) % 2) == 0) begin : g_hi
        assign st[s+1][i] = (st[s][i] < st[s][i-1]) ? st[s][i-1] : st[s][i];
      end else begin : g_pass
        assign st[s+1][i] = st[s][i];
      end
    end
  end

  for (genvar k = 0; k < KEEP; k++) begin : g_out
    assign key_o[k*KEY_W +: KEY_W] = st[N][k];
  end
endmodule

// File: rtl/psort_rank_sel.sv
`timescale 1ns/1ps
// Rank-based partial selection: slot s receives the key with rank s.
// Keys must be unique (parent and pattern fields guarantee this).
module psort_rank_sel #(
  parameter int unsigned N     = 8,
  parameter int unsigned KEY_W = 12,
  parameter int unsigned KEEP  = 4
) (
  input  logic [N*KEY_W-1:0]    key_i,
  output logic [KEEP*KEY_W-1:0] key_o
);
  localparam int unsigned RANK_W = psort_pkg::idx_w(N);

  logic [KEY_W-1:0]  key  [N];
  logic [RANK_W-1:0] rank [N];

  for (genvar i = 0; i < N; i++) begin : g_rank
    assign key[i] = key_i[i*KEY_W +: KEY_W];
    always_comb begin
      rank[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (j != i && key[j] < key[i]) rank[i] = rank[i] + RANK_W'(1);
      end
    end
  end

  for (genvar s = 0; s < KEEP; s++) begin : g_slot
    logic [KEY_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < N; i++) begin
        if (rank[i] == RANK_W'(s)) acc = acc | key[i];
      end
    end
    assign key_o[s*KEY_W +: KEY_W] = acc;
  end
endmodule

// File: rtl/psort_two_stage.sv
`timescale 1ns/1ps
module psort_two_stage #(
  parameter int unsigned NUM_PATHS = psort_pkg::DEF_PATHS,
  parameter int unsigned STEP_BITS = psort_pkg::DEF_STEP_BITS,
  parameter int unsigned KEEP      = psort_pkg::DEF_KEEP,
  parameter int unsigned METRIC_W  = psort_pkg::DEF_METRIC_W,
  localparam int unsigned FANOUT   = 1 << STEP_BITS,
  localparam int unsigned NUM_CAND = NUM_PATHS * FANOUT,
  localparam int unsigned PAR_W    = psort_pkg::idx_w(NUM_PATHS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            valid_i,
  input  logic [NUM_CAND*METRIC_W-1:0]    metric_i,
  output logic                            valid_o,
  output logic [NUM_PATHS*PAR_W-1:0]      parent_o,
  output logic [NUM_PATHS*STEP_BITS-1:0]  pattern_o,
  output logic [NUM_PATHS*METRIC_W-1:0]   metric_o
);
  localparam int unsigned KEY_W   = METRIC_W + PAR_W + STEP_BITS;
  localparam int unsigned NUM_MID = NUM_PATHS * KEEP;

  // key = {metric, parent, pattern}: smaller key wins, ties resolve by index
  logic [NUM_MID*KEY_W-1:0]   s1_d, s1_q;
  logic [NUM_PATHS*KEY_W-1:0] s2_d, s2_q;
  logic                       s1_valid, s2_valid;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    logic [FANOUT*KEY_W-1:0] cand;
    for (genvar t = 0; t < FANOUT; t++) begin : g_cand
      assign cand[t*KEY_W +: KEY_W] =
        {metric_i[(p*FANOUT+t)*METRIC_W +: METRIC_W], PAR_W'(p), STEP_BITS'(t)};
    end
    psort_cx_sort #(.N(FANOUT), .KEY_W(KEY_W), .KEEP(KEEP)) u_stage1 (
      .key_i(cand),
      .key_o(s1_d[p*KEEP*KEY_W +: KEEP*KEY_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_q     <= '0;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) s1_q <= s1_d;
    end
  end

  psort_rank_sel #(.N(NUM_MID), .KEY_W(KEY_W), .KEEP(NUM_PATHS)) u_stage2 (
    .key_i(s1_q),
    .key_o(s2_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid <= 1'b0;
      s2_q     <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) s2_q <= s2_d;
    end
  end

  assign valid_o = s2_valid;

  for (genvar k = 0; k < NUM_PATHS; k++) begin : g_dec
    logic [KEY_W-1:0] ent;
    assign ent = s2_q[k*KEY_W +: KEY_W];
    assign pattern_o[k*STEP_BITS +: STEP_BITS] = ent[STEP_BITS-1:0];
    assign parent_o[k*PAR_W +: PAR_W]          = ent[STEP_BITS +: PAR_W];
    assign metric_o[k*METRIC_W +: METRIC_W]    = ent[KEY_W-1 -: METRIC_W];
  end
endmodule

// File: rtl/psort_checker.sv
`timescale 1ns/1ps
module psort_checker #(
  parameter int unsigned NUM_PATHS = 4,
  parameter int unsigned STEP_BITS = 2,
  parameter int unsigned KEEP      = 2,
  parameter int unsigned METRIC_W  = 8,
  parameter int unsigned PAR_W     = 2
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           valid_i,
  input logic                           valid_o,
  input logic [NUM_PATHS*PAR_W-1:0]     parent_o,
  input logic [NUM_PATHS*STEP_BITS-1:0] pattern_o,
  input logic [NUM_PATHS*METRIC_W-1:0]  metric_o
);
  localparam int unsigned KEY_W = METRIC_W + PAR_W + STEP_BITS;

  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  logic [KEY_W-1:0] key [NUM_PATHS];
  logic sorted_ok, distinct_ok, cap_ok;
  int   cnt;

  always_comb begin
    for (int k = 0; k < NUM_PATHS; k++)
      key[k] = {metric_o[k*METRIC_W +: METRIC_W], parent_o[k*PAR_W +: PAR_W],
                pattern_o[k*STEP_BITS +: STEP_BITS]};
    sorted_ok = 1'b1;
    for (int k = 1; k < NUM_PATHS; k++)
      if (!(key[k-1] < key[k])) sorted_ok = 1'b0;
    distinct_ok = 1'b1;
    for (int a = 0; a < NUM_PATHS; a++)
      for (int b = a + 1; b < NUM_PATHS; b++)
        if (key[a][PAR_W+STEP_BITS-1:0] == key[b][PAR_W+STEP_BITS-1:0]) distinct_ok = 1'b0;
    cap_ok = 1'b1;
    for (int p = 0; p < NUM_PATHS; p++) begin
      cnt = 0;
      for (int k = 0; k < NUM_PATHS; k++)
        if (parent_o[k*PAR_W +: PAR_W] == PAR_W'(p)) cnt++;
      if (cnt > int'(KEEP)) cap_ok = 1'b0;
    end
  end

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_rst == 2'd2 |-> valid_o == $past(valid_i, 2));

  assert_sorted_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sorted_ok);

  assert_parent_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cap_ok);

  assert_distinct_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> distinct_ok);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(metric_o) && $stable(parent_o) && $stable(pattern_o)));
endmodule

bind psort_two_stage psort_checker #(
  .NUM_PATHS(NUM_PATHS), .STEP_BITS(STEP_BITS), .KEEP(KEEP),
  .METRIC_W(METRIC_W), .PAR_W(PAR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .valid_o(valid_o),
  .parent_o(parent_o), .pattern_o(pattern_o), .metric_o(metric_o)
);

// File: tb/psort_two_stage_tb.sv
`timescale 1ns/1ps
module psort_two_stage_tb;
  localparam int L = 4, B = 2, Q = 2, W = 8, F = 4, NC = 16, PW = 2, NM = 8;

  logic clk = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [NC*W-1:0] metric_i = '0;
  logic            valid_o;
  logic [L*PW-1:0] parent_o;
  logic [L*B-1:0]  pattern_o;
  logic [L*W-1:0]  metric_o;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [W-1:0]  fr [8][NC];
  logic [15:0]   lfsr = 16'hACE1;

  always #10 clk = ~clk;

  psort_two_stage u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .metric_i(metric_i),
    .valid_o(valid_o), .parent_o(parent_o), .pattern_o(pattern_o), .metric_o(metric_o)
  );

  function automatic logic [15:0] rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  function automatic int okey(int m, int p, int t);
    return m * 16 + p * 4 + t;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // model from the requirements: best Q per parent, then best L overall
  task automatic model(int f, output int ep[L], output int et[L], output int em[L]);
    int wp[NM], wt[NM], wm[NM];
    bit used[NM];
    bit taken[F];
    int n = 0;
    for (int i = 0; i < NM; i++) used[i] = 1'b0;
    for (int p = 0; p < L; p++) begin
      for (int t = 0; t < F; t++) taken[t] = 1'b0;
      for (int r = 0; r < Q; r++) begin
        int best = -1;
        for (int t = 0; t < F; t++)
          if (!taken[t] && (best < 0 || fr[f][p*F+t] < fr[f][p*F+best])) best = t;
        taken[best] = 1'b1;
        wp[n] = p; wt[n] = best; wm[n] = int'(fr[f][p*F+best]); n++;
      end
    end
    for (int k = 0; k < L; k++) begin
      int bi = -1;
      for (int i = 0; i < NM; i++)
        if (!used[i] && (bi < 0 || okey(wm[i], wp[i], wt[i]) < okey(wm[bi], wp[bi], wt[bi]))) bi = i;
      used[bi] = 1'b1;
      ep[k] = wp[bi]; et[k] = wt[bi]; em[k] = wm[bi];
    end
  endtask

  task automatic check_out(int f, string tag);
    int ep[L], et[L], em[L];
    model(f, ep, et, em);
    for (int k = 0; k < L; k++) begin
      int ap = int'(parent_o[k*PW +: PW]);
      int at = int'(pattern_o[k*B +: B]);
      int am = int'(metric_o[k*W +: W]);
      chk(ap == ep[k] && at == et[k] && am == em[k], "R3 R5", tag,
          okey(am, ap, at), okey(em[k], ep[k], et[k]));
    end
    for (int a = 0; a < L; a++)
      for (int b = a + 1; b < L; b++)
        chk({parent_o[a*PW +: PW], pattern_o[a*B +: B]} != {parent_o[b*PW +: PW], pattern_o[b*B +: B]},
            "R7", tag, a, b);
  endtask

  task automatic drive(int f);
    valid_i = 1'b1;
    for (int c = 0; c < NC; c++) metric_i[c*W +: W] = fr[f][c];
  endtask

  task automatic run_stream(int n, string tag);
    for (int k = 0; k <= n + 2; k++) begin
      @(negedge clk);
      if (k == 1) chk(valid_o == 1'b0, "R2", {tag, " early"}, int'(valid_o), 0);
      if (k >= 2 && k < n + 2) begin
        chk(valid_o == 1'b1, "R2 R8", tag, int'(valid_o), 1);
        check_out(k - 2, tag);
      end
      if (k == n + 2) begin
        chk(valid_o == 1'b0, "R2", {tag, " one-cycle"}, int'(valid_o), 0);
        check_out(n - 1, {tag, " R9 hold"});
      end
      if (k < n) drive(k);
      else begin
        valid_i = 1'b0;
        for (int c = 0; c < 8; c++) metric_i[c*16 +: 16] = rnd();
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0 && parent_o == '0 && pattern_o == '0 && metric_o == '0,
        "R1", "in reset", int'(valid_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(valid_o == 1'b0 && metric_o == '0, "R1", "after reset", int'(valid_o), 0);
  endtask

  task automatic t_spread();
    for (int c = 0; c < NC; c++) fr[0][c] = W'((c * 37 + 11) % 256);
    run_stream(1, "spread");
  endtask

  task automatic t_approx();
    int cnt = 0;
    for (int c = 0; c < NC; c++) fr[0][c] = (c < F) ? W'(c + 1) : W'(100 + c);
    run_stream(1, "approx");
    for (int k = 0; k < L; k++) if (parent_o[k*PW +: PW] == 2'd0) cnt++;
    chk(cnt == Q, "R4", "parent 0 share", cnt, Q);
    chk(metric_o[2*W +: W] == 8'd104, "R4", "entry 2 from path 1", int'(metric_o[2*W +: W]), 104);
  endtask

  task automatic t_ties();
    for (int c = 0; c < NC; c++) fr[0][c] = 8'd77;
    run_stream(1, "ties");
    chk(parent_o == 8'b01_01_00_00 && pattern_o == 8'b01_00_01_00, "R6", "tie order",
        int'({parent_o, pattern_o}), int'({8'b01_01_00_00, 8'b01_00_01_00}));
  endtask

  task automatic t_extremes();
    for (int c = 0; c < NC; c++) fr[0][c] = 8'd255;
    fr[0][15] = 8'd0;
    fr[0][8]  = 8'd0;
    run_stream(1, "extremes R3");
  endtask

  task automatic t_stream();
    for (int f = 0; f < 6; f++)
      for (int c = 0; c < NC; c++) fr[f][c] = W'(rnd());
    run_stream(6, "back-to-back R8");
  endtask

  task automatic t_random();
    for (int r = 0; r < 12; r++) begin
      for (int f = 0; f < 3; f++)
        for (int c = 0; c < NC; c++)
          fr[f][c] = (r % 2 == 0) ? W'(rnd() & 16'h0007) : W'(rnd());
      run_stream(3, "random");
    end
  endtask

  initial begin
    t_reset();
    t_spread();
    t_approx();
    t_ties();
    t_extremes();
    t_stream();
    t_random();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule